// File: doc/BRIEF.md
# Flagless Load/Store Processor Core

This block is a multicycle 32-bit processor core for a word-addressed machine. Every instruction is one 32-bit word split into a 6-bit opcode (bits 31:26), a first register field (25:21), a second register field (20:16) and a 16-bit operand field (15:0). For register-register forms, the third register number sits in the low five bits of the operand field. No condition flags exist. Comparison instructions write 1 or 0 into a general register, and the conditional jumps test a named register for zero or nonzero.

The core reaches one single-ported word memory through a request/acknowledge pair. The request holds steady until the memory acknowledges it, and read data is taken in the acknowledge cycle. Instruction fetches and data accesses share the port. A simple instruction costs a fetch access plus one execute cycle. Loads and stores add one data access. A pop adds a further cycle to step its stack pointer down.

Service traps with a nonzero code are shown on output ports for one cycle. Trap code 0 parks the core. An undefined opcode also parks it and raises an illegal-instruction flag.

Top module: `rtc_core`

## Requirements
- R1: Opcodes 10..25 apply the operation set add, sub, mul, div, and, or, xor, eq, ne, lt, le, gt, ge, shl, shr, mod to R[r2] and the sign-extended operand. Opcodes 32..47 apply the same set, in the same order, to R[r2] and R[r3]. Comparisons are signed and yield 1 or 0, and shr is logical.
- R2: Opcode 1 loads the word at the zero-extended 16-bit operand into R[r1], and opcode 3 stores R[r1] there. A memory request stays asserted with a stable address until it is acknowledged.
- R3: Opcodes 2 (load) and 4 (store of R[r1]) use the address R[r2] plus the sign-extended operand.
- R4: Opcodes 48 (load) and 49 (store of R[r1]) use the address R[r2]+R[r3].
- R5: Opcode 6 jumps to the operand. Opcode 8 jumps when R[r1] is nonzero, and opcode 9 jumps when R[r1] is zero, so opcode 9 with r1=0 always jumps. Otherwise execution falls through.
- R6: Opcode 7 writes the address of the following instruction into R[r1] and jumps to the operand. Opcode 50 jumps to R[r1].
- R7: Opcode 52 first adds 1 to R[r1] and then stores R[r2] at the new R[r1]. Opcode 53 loads the word at R[r1] into R[r2] and then subtracts 1 from R[r1].
- R8: Register 0 reads as zero, and any write to it is dropped.
- R9: Opcodes 0 and 5 change nothing but the program counter.
- R10: Opcode 51 with operand 0 sets `halted`. After that the core makes no further memory requests and its program counter stays unchanged.
- R11: Opcode 51 with a nonzero operand pulses `svc_valid` for one cycle, with `svc_code` set to the operand and `svc_arg` set to R[r1]. Execution then continues.
- R12: Opcodes 26..31 and 54..63 set `illegal` and `halted` and stop the core.
- R13: While reset is held, `halted`, `illegal` and `svc_valid` are low and the fetch address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the current request |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an undefined opcode |
| svc_valid | output | 1 | One-cycle service trap strobe |
| svc_code | output | 16 | Service code from the operand field |
| svc_arg | output | 32 | Value of R[r1] for the service |

## Verification
The checker assumes that the memory raises `mem_ack` only in a cycle where `mem_req` is high, and that it answers reads in that same cycle. The bench memory follows this rule: it decides at the falling edge, acknowledges only a request it can see, and in one run it inserts a wait cycle in front of every acknowledge. This tests that the request is held. The test programs read only registers they have already written, keep every address inside the bench memory, and never divide by zero.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned ILEN = 32;
  localparam int unsigned REGW = 5;
  localparam int unsigned IMMW = 16;
  localparam int unsigned OPW  = 6;

  localparam logic [OPW-1:0] OP_NOP_A  = 6'd0;
  localparam logic [OPW-1:0] OP_LD_ABS = 6'd1;
  localparam logic [OPW-1:0] OP_LD_DSP = 6'd2;
  localparam logic [OPW-1:0] OP_ST_ABS = 6'd3;
  localparam logic [OPW-1:0] OP_ST_DSP = 6'd4;
  localparam logic [OPW-1:0] OP_NOP_B  = 6'd5;
  localparam logic [OPW-1:0] OP_JMP    = 6'd6;
  localparam logic [OPW-1:0] OP_JAL    = 6'd7;
  localparam logic [OPW-1:0] OP_JT     = 6'd8;
  localparam logic [OPW-1:0] OP_JF     = 6'd9;
  localparam logic [OPW-1:0] OP_ALUI_L = 6'd10;
  localparam logic [OPW-1:0] OP_ALUI_H = 6'd25;
  localparam logic [OPW-1:0] OP_ALUR_L = 6'd32;
  localparam logic [OPW-1:0] OP_ALUR_H = 6'd47;
  localparam logic [OPW-1:0] OP_LD_IDX = 6'd48;
  localparam logic [OPW-1:0] OP_ST_IDX = 6'd49;
  localparam logic [OPW-1:0] OP_RET    = 6'd50;
  localparam logic [OPW-1:0] OP_TRAP   = 6'd51;
  localparam logic [OPW-1:0] OP_PUSH   = 6'd52;
  localparam logic [OPW-1:0] OP_POP    = 6'd53;

  // order equals the offset inside each arithmetic opcode range
  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV, ALU_AND, ALU_OR, ALU_XOR, ALU_EQ,
    ALU_NE, ALU_LT, ALU_LE, ALU_GT, ALU_GE, ALU_SHL, ALU_SHR, ALU_MOD
  } alu_op_e;

  typedef enum logic [3:0] {
    K_NOP, K_ALU, K_LD, K_ST, K_JMP, K_JT, K_JF, K_JAL,
    K_RET, K_TRAP, K_PUSH, K_POP, K_ILL
  } kind_e;

  typedef enum logic [1:0] {AM_ABS, AM_DSP, AM_IDX} amode_e;

  typedef struct packed {
    kind_e   kind;
    amode_e  amode;
    logic    use_imm;
    alu_op_e alu_op;
  } ctl_t;

  typedef enum logic [2:0] {
    S_FETCH, S_EXEC, S_MEM, S_SPDEC, S_HALT, S_ILL
  } state_e;

endpackage

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [REGW-1:0] ra_addr,
  input  logic [REGW-1:0] rb_addr,
  input  logic [REGW-1:0] rc_addr,
  output logic [XLEN-1:0] ra_data,
  output logic [XLEN-1:0] rb_data,
  output logic [XLEN-1:0] rc_data,
  input  logic            wr_en,
  input  logic [REGW-1:0] wr_addr,
  input  logic [XLEN-1:0] wr_data
);

  localparam int unsigned NREG = 1 << REGW;

  logic [XLEN-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign q[i] = '0;
    end else begin : g_store
      logic load;
      assign load = wr_en && (wr_addr == REGW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q[i] <= '0;
        end else if (load) begin
          q[i] <= wr_data;
        end
      end
    end
  end

  assign ra_data = q[ra_addr];
  assign rb_data = q[rb_addr];
  assign rc_data = q[rc_addr];

endmodule

// File: rtl/rtc_alu.sv
module rtc_alu
  import rtc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);

  localparam int unsigned SHW = $clog2(XLEN);
  localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

  logic signed [XLEN-1:0] as, bs;
  logic                   bzero;

  assign as    = $signed(a);
  assign bs    = $signed(b);
  assign bzero = (b == '0);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_MUL: y = a * b;
      ALU_DIV: y = bzero ? '0 : $unsigned(as / bs);
      ALU_MOD: y = bzero ? '0 : $unsigned(as % bs);
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_EQ:  y = (a == b)  ? ONE : '0;
      ALU_NE:  y = (a != b)  ? ONE : '0;
      ALU_LT:  y = (as < bs)  ? ONE : '0;
      ALU_LE:  y = (as <= bs) ? ONE : '0;
      ALU_GT:  y = (as > bs)  ? ONE : '0;
      ALU_GE:  y = (as >= bs) ? ONE : '0;
      ALU_SHL: y = a << b[SHW-1:0];
      ALU_SHR: y = a >> b[SHW-1:0];
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/rtc_decode.sv
module rtc_decode
  import rtc_pkg::*;
(
  input  logic [OPW-1:0] op,
  output ctl_t           ctl
);

  logic [3:0] off_imm;

  // op-10 lies in 0..15 inside the immediate range, so four bits suffice
  assign off_imm = op[3:0] - 4'd10;

  always_comb begin
    ctl.kind    = K_ILL;
    ctl.amode   = AM_ABS;
    ctl.use_imm = 1'b0;
    ctl.alu_op  = ALU_ADD;
    if (op >= OP_ALUI_L && op <= OP_ALUI_H) begin
      ctl.kind    = K_ALU;
      ctl.use_imm = 1'b1;
      ctl.alu_op  = alu_op_e'(off_imm);
    end else if (op >= OP_ALUR_L && op <= OP_ALUR_H) begin
      ctl.kind   = K_ALU;
      ctl.alu_op = alu_op_e'(op[3:0]);
    end else begin
      case (op)
        OP_NOP_A, OP_NOP_B: ctl.kind = K_NOP;
        OP_LD_ABS: ctl.kind = K_LD;
        OP_ST_ABS: ctl.kind = K_ST;
        OP_LD_DSP: begin ctl.kind = K_LD; ctl.amode = AM_DSP; end
        OP_ST_DSP: begin ctl.kind = K_ST; ctl.amode = AM_DSP; end
        OP_LD_IDX: begin ctl.kind = K_LD; ctl.amode = AM_IDX; end
        OP_ST_IDX: begin ctl.kind = K_ST; ctl.amode = AM_IDX; end
        OP_JMP:  ctl.kind = K_JMP;
        OP_JAL:  ctl.kind = K_JAL;
        OP_JT:   ctl.kind = K_JT;
        OP_JF:   ctl.kind = K_JF;
        OP_RET:  ctl.kind = K_RET;
        OP_TRAP: ctl.kind = K_TRAP;
        OP_PUSH: ctl.kind = K_PUSH;
        OP_POP:  ctl.kind = K_POP;
        default: ctl.kind = K_ILL;
      endcase
    end
  end

endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'd0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_ack,
  output logic            halted,
  output logic            illegal,
  output logic            svc_valid,
  output logic [IMMW-1:0] svc_code,
  output logic [XLEN-1:0] svc_arg
);

  localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

  state_e            state_q, state_d;
  logic [XLEN-1:0]   pc_q, pc_d, pc_inc;
  logic              pc_en;
  logic [ILEN-1:0]   ir_q;
  logic              ir_en;
  logic [XLEN-1:0]   maddr_q, maddr_d, mdata_q, mdata_d;
  logic              mwe_q, mwe_d, mreg_en;

  logic [OPW-1:0]    f_op;
  logic [REGW-1:0]   f_r1, f_r2, f_r3;
  logic [IMMW-1:0]   f_d;
  logic [XLEN-1:0]   d_sext, d_zext;
  ctl_t              ctl;

  logic [XLEN-1:0]   rd_a, rd_b, rd_c;
  logic              rf_we;
  logic [REGW-1:0]   rf_waddr;
  logic [XLEN-1:0]   rf_wdata;
  logic [XLEN-1:0]   alu_b, alu_y, ea;

  assign f_op   = ir_q[31:26];
  assign f_r1   = ir_q[25:21];
  assign f_r2   = ir_q[20:16];
  assign f_d    = ir_q[15:0];
  assign f_r3   = f_d[REGW-1:0];
  assign d_sext = {{(XLEN-IMMW){f_d[IMMW-1]}}, f_d};
  assign d_zext = {{(XLEN-IMMW){1'b0}}, f_d};
  assign pc_inc = pc_q + ONE;

  rtc_decode u_dec (
    .op  (f_op),
    .ctl (ctl)
  );

  rtc_regfile #(.XLEN(XLEN)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_addr (f_r1),
    .rb_addr (f_r2),
    .rc_addr (f_r3),
    .ra_data (rd_a),
    .rb_data (rd_b),
    .rc_data (rd_c),
    .wr_en   (rf_we),
    .wr_addr (rf_waddr),
    .wr_data (rf_wdata)
  );

  assign alu_b = ctl.use_imm ? d_sext : rd_c;

  rtc_alu #(.XLEN(XLEN)) u_alu (
    .op (ctl.alu_op),
    .a  (rd_b),
    .b  (alu_b),
    .y  (alu_y)
  );

  // effective address of a load or store
  always_comb begin
    case (ctl.amode)
      AM_DSP:  ea = rd_b + d_sext;
      AM_IDX:  ea = rd_b + rd_c;
      default: ea = d_zext;
    endcase
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    pc_d     = pc_inc;
    pc_en    = 1'b0;
    ir_en    = 1'b0;
    mreg_en  = 1'b0;
    maddr_d  = maddr_q;
    mdata_d  = mdata_q;
    mwe_d    = mwe_q;
    rf_we    = 1'b0;
    rf_waddr = f_r1;
    rf_wdata = alu_y;
    case (state_q)
      S_FETCH: begin
        if (mem_ack) begin
          ir_en   = 1'b1;
          state_d = S_EXEC;
        end
      end
      S_EXEC: begin
        state_d = S_FETCH;
        case (ctl.kind)
          K_NOP: pc_en = 1'b1;
          K_ALU: begin
            rf_we = 1'b1;
            pc_en = 1'b1;
          end
          K_LD: begin
            mreg_en = 1'b1;
            maddr_d = ea;
            mwe_d   = 1'b0;
            state_d = S_MEM;
          end
          K_ST: begin
            mreg_en = 1'b1;
            maddr_d = ea;
            mdata_d = rd_a;
            mwe_d   = 1'b1;
            state_d = S_MEM;
          end
          K_JMP: begin
            pc_en = 1'b1;
            pc_d  = d_zext;
          end
          K_JT: begin
            pc_en = 1'b1;
            if (rd_a != '0) pc_d = d_zext;
          end
          K_JF: begin
            pc_en = 1'b1;
            if (rd_a == '0) pc_d = d_zext;
          end
          K_JAL: begin
            rf_we    = 1'b1;
            rf_wdata = pc_inc;
            pc_en    = 1'b1;
            pc_d     = d_zext;
          end
          K_RET: begin
            pc_en = 1'b1;
            pc_d  = rd_a;
          end
          K_TRAP: begin
            if (f_d == '0) begin
              state_d = S_HALT;
            end else begin
              pc_en = 1'b1;
            end
          end
          K_PUSH: begin
            rf_we    = 1'b1;
            rf_wdata = rd_a + ONE;
            mreg_en  = 1'b1;
            maddr_d  = rd_a + ONE;
            mdata_d  = rd_b;
            mwe_d    = 1'b1;
            state_d  = S_MEM;
          end
          K_POP: begin
            mreg_en = 1'b1;
            maddr_d = rd_a;
            mwe_d   = 1'b0;
            state_d = S_MEM;
          end
          default: state_d = S_ILL;
        endcase
      end
      S_MEM: begin
        if (mem_ack) begin
          if (ctl.kind == K_LD) begin
            rf_we    = 1'b1;
            rf_wdata = mem_rdata;
          end
          if (ctl.kind == K_POP) begin
            rf_we    = 1'b1;
            rf_waddr = f_r2;
            rf_wdata = mem_rdata;
            state_d  = S_SPDEC;
          end else begin
            pc_en   = 1'b1;
            state_d = S_FETCH;
          end
        end
      end
      S_SPDEC: begin
        rf_we    = 1'b1;
        rf_wdata = rd_a - ONE;
        pc_en    = 1'b1;
        state_d  = S_FETCH;
      end
      default: state_d = state_q;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_FETCH;
      pc_q    <= XLEN'(RESET_PC);
      ir_q    <= '0;
      maddr_q <= '0;
      mdata_q <= '0;
      mwe_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (pc_en) pc_q <= pc_d;
      if (ir_en) ir_q <= mem_rdata[ILEN-1:0];
      if (mreg_en) begin
        maddr_q <= maddr_d;
        mdata_q <= mdata_d;
        mwe_q   <= mwe_d;
      end
    end
  end

  assign mem_req   = (state_q == S_FETCH) || (state_q == S_MEM);
  assign mem_we    = (state_q == S_MEM) && mwe_q;
  assign mem_addr  = (state_q == S_FETCH) ? pc_q : maddr_q;
  assign mem_wdata = mdata_q;
  assign halted    = (state_q == S_HALT) || (state_q == S_ILL);
  assign illegal   = (state_q == S_ILL);
  assign svc_valid = (state_q == S_EXEC) && (ctl.kind == K_TRAP) && (f_d != '0);
  assign svc_code  = f_d;
  assign svc_arg   = rd_a;

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_ack,
  input logic            mem_we,
  input logic [XLEN-1:0] mem_addr,
  input logic            halted,
  input logic            illegal,
  input logic            svc_valid,
  input logic [XLEN-1:0] pc
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R2

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req); // R10

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R10

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(pc)); // R10

  AST_SVC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |=> !svc_valid); // R11

  AST_SVC_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> !mem_req && !halted); // R11

  AST_ILL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> halted); // R12

endmodule

bind rtc_core rtc_core_chk #(.XLEN(XLEN)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .halted    (halted),
  .illegal   (illegal),
  .svc_valid (svc_valid),
  .pc        (pc_q)
);

// File: tb/test_rtc_core.sv
module test_rtc_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        halted, illegal, svc_valid;
  logic [15:0] svc_code;
  logic [31:0] svc_arg;

  always #5 clk = ~clk;

  rtc_core i_rtc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .halted    (halted),
    .illegal   (illegal),
    .svc_valid (svc_valid),
    .svc_code  (svc_code),
    .svc_arg   (svc_arg)
  );

  typedef struct {
    bit          is_svc;
    logic [31:0] a;
    logic [31:0] b;
    string       tag;
  } item_t;

  item_t       exp_q[$];
  logic [31:0] mem [256];
  int          n_chk = 0;
  int          n_err = 0;
  bit          slow  = 0;
  bit          gap   = 0;
  int          halted_reqs = 0;

  function automatic logic [31:0] enc(int op, int a, int b, int d);
    logic [5:0] o = op[5:0];
    logic [4:0] x = a[4:0];
    logic [4:0] y = b[4:0];
    logic [15:0] z = d[15:0];
    return {o, x, y, z};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic expect_wr(int addr, int data, string tag);
    item_t it;
    it.is_svc = 0; it.a = addr; it.b = data; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic expect_svc(int code, int arg, string tag);
    item_t it;
    it.is_svc = 1; it.a = code; it.b = arg; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: compare observed events against the scoreboard queue
  task automatic observe(bit is_svc, logic [31:0] a, logic [31:0] b);
    item_t it;
    if (exp_q.size() == 0) begin
      chk(0, "R5", is_svc ? "unexpected service" : "unexpected write", a, 32'hffffffff);
      return;
    end
    it = exp_q.pop_front();
    chk(it.is_svc == is_svc, it.tag, "event kind", 32'(is_svc), 32'(it.is_svc));
    chk(it.a == a, it.tag, is_svc ? "service code" : "write address", a, it.a);
    chk(it.b == b, it.tag, is_svc ? "service arg" : "write data", b, it.b);
  endtask

  // memory model and monitor, decided at the falling edge
  task automatic serve();
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (rst_n) begin
        if (svc_valid) observe(1, 32'(svc_code), svc_arg);
        if (halted && mem_req) halted_reqs++;
        if (mem_req) begin
          if (slow && !gap) begin
            gap = 1;
          end else begin
            gap = 0;
            mem_ack   = 1'b1;
            mem_rdata = mem[mem_addr[7:0]];
            if (mem_we) begin
              mem[mem_addr[7:0]] = mem_wdata;
              observe(0, mem_addr, mem_wdata);
            end
          end
        end
      end
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic run(int limit);
    int cyc = 0;
    halted_reqs = 0;
    @(negedge clk);
    rst_n = 1'b1;
    while (!halted && cyc < limit) begin
      @(negedge clk);
      cyc++;
    end
    if (!halted) chk(0, "R10", "watchdog expired", 32'(cyc), 32'(limit));
    repeat (10) @(negedge clk);
  endtask

  initial begin
    rst_n     = 1'b0;
    mem_ack   = 1'b0;
    mem_rdata = '0;
    clear_mem();
    fork serve(); join_none

    // program one: arithmetic, all address modes, control flow, stack
    mem[0]  = enc(10, 1, 0, 5);
    mem[1]  = enc(10, 2, 0, -3);
    mem[2]  = enc(32, 3, 1, 2);
    mem[3]  = enc(3, 3, 0, 128);
    mem[4]  = enc(33, 4, 2, 1);
    mem[5]  = enc(3, 4, 0, 129);
    mem[6]  = enc(12, 5, 1, 7);
    mem[7]  = enc(3, 5, 0, 130);
    mem[8]  = enc(41, 6, 2, 1);
    mem[9]  = enc(3, 6, 0, 131);
    mem[10] = enc(10, 0, 0, 9);
    mem[11] = enc(3, 0, 0, 132);
    mem[12] = enc(23, 7, 1, 4);
    mem[13] = enc(3, 7, 0, 133);
    mem[14] = enc(35, 8, 7, 1);
    mem[15] = enc(3, 8, 0, 134);
    mem[16] = enc(25, 9, 1, 3);
    mem[17] = enc(3, 9, 0, 135);
    mem[18] = enc(4, 1, 7, 2);
    mem[19] = enc(2, 10, 7, 2);
    mem[20] = enc(3, 10, 0, 136);
    mem[21] = enc(49, 3, 7, 1);
    mem[22] = enc(48, 11, 7, 1);
    mem[23] = enc(3, 11, 0, 137);
    mem[24] = enc(1, 12, 0, 128);
    mem[25] = enc(10, 12, 12, 1);
    mem[26] = enc(3, 12, 0, 138);
    mem[27] = enc(8, 1, 0, 29);
    mem[28] = enc(3, 1, 0, 139);
    mem[29] = enc(8, 0, 0, 31);
    mem[30] = enc(51, 1, 0, 1);
    mem[31] = enc(9, 6, 0, 33);
    mem[32] = enc(9, 0, 0, 34);
    mem[33] = enc(3, 0, 0, 139);
    mem[34] = enc(7, 13, 0, 40);
    mem[35] = enc(3, 13, 0, 140);
    mem[36] = enc(0, 0, 0, 0);
    mem[37] = enc(5, 0, 0, 0);
    mem[38] = enc(6, 0, 0, 50);
    mem[40] = enc(10, 14, 0, 60);
    mem[41] = enc(52, 14, 1, 0);
    mem[42] = enc(52, 14, 5, 0);
    mem[43] = enc(53, 14, 15, 0);
    mem[44] = enc(3, 14, 0, 141);
    mem[45] = enc(3, 15, 0, 142);
    mem[46] = enc(50, 13, 0, 0);
    mem[50] = enc(51, 0, 0, 0);

    expect_wr(128, 2, "R1 reg-reg add");
    expect_wr(129, -8, "R1 reg-reg sub");
    expect_wr(130, 35, "R1 imm mul");
    expect_wr(131, 1, "R1 signed lt");
    expect_wr(132, 0, "R8 r0 write dropped");
    expect_wr(133, 80, "R1 imm shl");
    expect_wr(134, 16, "R1 reg-reg div");
    expect_wr(135, 2, "R1 imm mod");
    expect_wr(82, 5, "R3 displacement store");
    expect_wr(136, 5, "R3 displacement load");
    expect_wr(85, 2, "R4 index store");
    expect_wr(137, 2, "R4 index load");
    expect_wr(138, 3, "R2 absolute load");
    expect_svc(1, 5, "R11 service code 1");
    expect_wr(61, 5, "R7 push pre-increment");
    expect_wr(62, 35, "R7 second push");
    expect_wr(141, 61, "R7 pop post-decrement");
    expect_wr(142, 35, "R7 pop data");
    expect_wr(140, 35, "R6 link is next address");

    #1;
    chk(halted == 1'b0, "R13", "halted in reset", 32'(halted), 0);
    chk(illegal == 1'b0, "R13", "illegal in reset", 32'(illegal), 0);
    chk(svc_valid == 1'b0, "R13", "svc_valid in reset", 32'(svc_valid), 0);
    chk(mem_addr == 32'd0, "R13", "fetch address in reset", mem_addr, 0);

    slow = 1;
    run(4000);
    chk(halted == 1'b1, "R10", "halted after code 0", 32'(halted), 1);
    chk(illegal == 1'b0, "R10", "illegal after code 0", 32'(illegal), 0);
    chk(halted_reqs == 0, "R10", "requests while halted", 32'(halted_reqs), 0);
    chk(exp_q.size() == 0, "R9", "events left after nops and jumps", 32'(exp_q.size()), 0);

    // program two: other service code, then an undefined opcode
    rst_n = 1'b0;
    exp_q.delete();
    repeat (2) @(negedge clk);
    clear_mem();
    mem[0] = enc(10, 1, 0, 1);
    mem[1] = enc(3, 1, 0, 128);
    mem[2] = enc(51, 1, 0, 7);
    mem[3] = enc(30, 0, 0, 0);
    mem[4] = enc(3, 1, 0, 129);
    expect_wr(128, 1, "R2 absolute store");
    expect_svc(7, 1, "R11 service code 7");
    slow = 0;
    run(2000);
    chk(illegal == 1'b1, "R12", "illegal after opcode 30", 32'(illegal), 1);
    chk(halted == 1'b1, "R12", "halted after opcode 30", 32'(halted), 1);
    chk(halted_reqs == 0, "R12", "requests after illegal", 32'(halted_reqs), 0);
    chk(exp_q.size() == 0, "R12", "events left", 32'(exp_q.size()), 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule